// File: doc/BRIEF.md
# Half-Period Clock Regenerator

This block rebuilds a clock with 50% duty from an input clock whose duty may be anywhere between 30% and 70%. The input period arrives already measured, as an 11-bit code. Its upper eight bits count whole cycles of the sampling clock. Its lower three bits count eighths of a sampling cycle. A single-cycle valid strobe delivers the code. The block halves the code. Each input rising edge then starts an output high time, and a falling point placed half a period later ends it. The falling edge of the input is never used.

Each output cycle of the sampling clock is written as a vector of eight sub-phase slots, earliest slot in bit 0. A downstream serializer or phase mixer turns the vector into a waveform. A set pulse from the input rising edge and a reset pulse from a half-period timer drive a set/reset latch, and the latch state fills the slots. A lock flag tells consumers when the regenerated clock can be trusted.

Top module: `dcc_half_period_regen`

## Requirements
- R1: After reset, `out_phases`, `clk_out` and `locked` are all 0.
- R2: Until the first `code_valid` strobe, `out_phases` stays all zero and `locked` stays 0, however `clk_in` toggles.
- R3: The half code is `{code_coarse, code_fine} >> 1`. Its whole-cycle part is `code_coarse >> 1`. Its slot part is `{code_coarse[0], code_fine[2:1]}`, so the coarse LSB carries into the slot MSB. Each output high run lasts exactly that many eighth-cycle slots, with bit i of `out_phases` standing for slot i.
- R4: Each detected rising edge of `clk_in` after a code is loaded starts exactly one high run. That cycle's vector is all ones.
- R5: The run ends in the cycle where the timer, restarted at 0 on the rising edge, equals the whole-cycle half code. In that vector only the slots below the slot half code are 1, and the latch is clear afterwards. At most one reset pulse fires per rising edge.
- R6: For input duties of 30%, 50% and 70% with the same code, the high run is the same. It is within one eighth-cycle step of half the input period.
- R7: When the set and reset pulses fall in the same cycle (whole-cycle half code 0), set wins. The vector is all ones and the output stays high.
- R8: `locked` rises in the cycle after the second input rising edge that follows a code load, which is inside the six-edge budget. A new `code_valid` clears it and restarts the count.
- R9: A newly loaded code governs every high run that starts after it, including recovery from the stuck-high state of R7.
- R10: `clk_out` equals slot 0 of `out_phases`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_in | input | 1 | Input clock with distorted duty, sampled by `clk` |
| code_valid | input | 1 | Strobe that loads a new period code |
| code_coarse | input | 8 | Period in whole sampling cycles |
| code_fine | input | 3 | Period remainder in eighths of a sampling cycle |
| clk_out | output | 1 | Regenerated clock level at slot 0 of each cycle |
| out_phases | output | 8 | Regenerated clock per eighth-cycle slot, bit 0 earliest |
| locked | output | 1 | Regenerated clock is valid |

## Verification
The set pulse from a rising edge and the reset pulse from the timer can fall in the same cycle only when the half period is shorter than one sampling cycle. The bench provokes this by loading a code of one whole cycle and zero fine part. It then judges the outcome at the output over several input periods, including the input's low phases: every vector must read all ones. It then loads a normal code and requires the exact high-run width again, so a latch that let reset win, or that stayed stuck, is caught. This also shows that a reset pulse arriving on a clear latch leaves no stray slots.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   localparam int unsigned LOCK_BUDGET = 6;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_SET   = 2'd1,
      ACT_CLEAR = 2'd2
   } latch_act_e;
endpackage

// File: rtl/dcc_rise_shot.sv
module dcc_rise_shot #(
   parameter int unsigned SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic rise
);
   logic level;
   logic level_d;

   generate
      if (SYNC == 0) begin : g_direct
         assign level = sig_in;
      end else begin : g_chain
         logic [SYNC-1:0] stages;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stages <= '0;
            else        stages <= (stages << 1) | SYNC'(sig_in);
         end
         assign level = stages[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level;
   end

   assign rise = level & ~level_d;

   // R4: one pulse per edge
   a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/dcc_fall_timer.sv
module dcc_fall_timer #(
   parameter int unsigned COARSE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                rise,
   input  logic [COARSE_W-1:0] half_coarse,
   output logic                fall
);
   logic [COARSE_W-1:0] cnt;
   logic [COARSE_W-1:0] cur;
   logic                done;
   logic                done_eff;

   assign cur      = rise ? '0 : cnt;
   assign done_eff = rise ? 1'b0 : done;
   assign fall     = en && !done_eff && (cur == half_coarse);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '1;
         done <= 1'b1;
      end else if (rise) begin
         cnt  <= COARSE_W'(1);
         done <= fall;
      end else begin
         if (cnt != '1) cnt <= cnt + 1'b1;
         if (fall)      done <= 1'b1;
      end
   end

   // R5: a single reset pulse per rising edge
   a_r5_fall_once: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> (!fall || rise));
endmodule

// File: rtl/dcc_phase_latch.sv
module dcc_phase_latch
   import dcc_pkg::*;
#(
   parameter int unsigned FINE_W = 3,
   localparam int unsigned SLOTS = 1 << FINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              set,
   input  logic              clr,
   input  logic [FINE_W-1:0] slot,
   output logic [SLOTS-1:0]  vec,
   output logic              q
);
   logic [SLOTS-1:0] mask;
   logic [SLOTS-1:0] vec_n;
   logic             q_n;
   latch_act_e       act;

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_mask
         assign mask[i] = (i < int'(slot));
      end
   endgenerate

   always_comb begin
      if (set)      act = ACT_SET;
      else if (clr) act = ACT_CLEAR;
      else          act = ACT_HOLD;
      vec_n = '0;
      q_n   = q;
      if (!en) begin
         q_n = 1'b0;
      end else begin
         unique case (act)
            ACT_SET: begin
               vec_n = '1;
               q_n   = 1'b1;
            end
            ACT_CLEAR: begin
               vec_n = q ? mask : '0;
               q_n   = 1'b0;
            end
            default: vec_n = {SLOTS{q}};
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec <= '0;
         q   <= 1'b0;
      end else begin
         vec <= vec_n;
         q   <= q_n;
      end
   end

   // R7: set wins over a coincident reset
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (en && set && clr) |=> (vec == '1 && q));
   // R5: a reset leaves the latch clear and the last slot low
   a_r5_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clr && !set) |=> (!q && !vec[SLOTS-1]));
   // R2: disabled latch emits nothing
   a_r2_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (vec == '0));
endmodule

// File: rtl/dcc_half_period_regen.sv
module dcc_half_period_regen
   import dcc_pkg::*;
#(
   parameter int unsigned COARSE_W   = 8,
   parameter int unsigned FINE_W     = 3,
   parameter int unsigned IN_SYNC    = 2,
   parameter int unsigned LOCK_EDGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clk_in,
   input  logic                       code_valid,
   input  logic [COARSE_W-1:0]        code_coarse,
   input  logic [FINE_W-1:0]          code_fine,
   output logic                       clk_out,
   output logic [(1 << FINE_W)-1:0]   out_phases,
   output logic                       locked
);
   localparam int unsigned CODE_W = COARSE_W + FINE_W;
   localparam int unsigned LCW    = $clog2(LOCK_EDGES + 1);

   generate
      if (FINE_W < 1 || FINE_W > 4) begin : g_bad_fine
         $error("FINE_W must lie in 1..4");
      end
      if (COARSE_W < 2) begin : g_bad_coarse
         $error("COARSE_W must be at least 2");
      end
      if (LOCK_EDGES < 1 || LOCK_EDGES > LOCK_BUDGET) begin : g_bad_lock
         $error("LOCK_EDGES outside the lock budget");
      end
   endgenerate

   logic [CODE_W-1:0]   half_w;
   logic [COARSE_W-1:0] half_coarse;
   logic [FINE_W-1:0]   half_fine;
   logic                armed;
   logic [LCW-1:0]      edges;
   logic                rise;
   logic                fall;
   logic                q;

   assign half_w = {code_coarse, code_fine} >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_coarse <= '0;
         half_fine   <= '0;
         armed       <= 1'b0;
         edges       <= '0;
         locked      <= 1'b0;
      end else if (code_valid) begin
         half_coarse <= half_w[CODE_W-1:FINE_W];
         half_fine   <= half_w[FINE_W-1:0];
         armed       <= 1'b1;
         edges       <= '0;
         locked      <= 1'b0;
      end else if (armed && rise && edges != LCW'(LOCK_EDGES)) begin
         edges <= edges + 1'b1;
         if (edges == LCW'(LOCK_EDGES - 1)) locked <= 1'b1;
      end
   end

   dcc_rise_shot #(.SYNC(IN_SYNC)) u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (clk_in),
      .rise   (rise)
   );

   dcc_fall_timer #(.COARSE_W(COARSE_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (armed),
      .rise        (rise),
      .half_coarse (half_coarse),
      .fall        (fall)
   );

   dcc_phase_latch #(.FINE_W(FINE_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (armed),
      .set   (rise),
      .clr   (fall),
      .slot  (half_fine),
      .vec   (out_phases),
      .q     (q)
   );

   assign clk_out = out_phases[0];

   // R2: nothing leaves the block before a code is loaded
   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (!locked && out_phases == '0));
   // R8: lock only follows an input rising edge
   a_r8_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(rise));
   // R7: stuck-high latch keeps the output full
   a_r7_high_full: assert property (@(posedge clk) disable iff (!rst_n)
      (q && $past(q) && armed) |-> (out_phases == '1));
endmodule

// File: tb/tb_dcc_half_period_regen.sv
`timescale 1ns/1ps
module tb_dcc_half_period_regen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_in = 1'b0;
   logic       code_valid = 1'b0;
   logic [7:0] code_coarse = '0;
   logic [2:0] code_fine = '0;
   logic       clk_out;
   logic [7:0] out_phases;
   logic       locked;

   int n_chk = 0, n_fail = 0;
   int m_chk = 0, m_fail = 0;
   int meas_en = 0;
   int exp_w = 0;
   int per_slots = 0;
   int acc = 0;
   int n_runs = 0;
   int idle_bad = 0;
   int stuck_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dcc_half_period_regen dut (
      .clk(clk), .rst_n(rst_n), .clk_in(clk_in), .code_valid(code_valid),
      .code_coarse(code_coarse), .code_fine(code_fine),
      .clk_out(clk_out), .out_phases(out_phases), .locked(locked)
   );

   function automatic int half_of(int c, int f);
      return ((c * 8) + f) >> 1;
   endfunction

   task automatic chk(bit ok, string req, int got, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, expv);
      end
   endtask

   // high-run measurement, R3/R6/R10
   always @(negedge clk) begin
      if (meas_en != 0) begin
         int pop;
         pop = $countones(out_phases);
         if (clk_out !== out_phases[0]) begin
            m_chk++; m_fail++;
            $display("FAIL R10: clk_out %0d slot0 %0d", clk_out, out_phases[0]);
         end
         if (pop == 8) acc += 8;
         else begin
            if (acc + pop > 0) begin
               n_runs++;
               m_chk++;
               if (acc + pop != exp_w) begin
                  m_fail++;
                  $display("FAIL R3: high slots got %0d expected %0d", acc + pop, exp_w);
               end
               m_chk++;
               if ((2 * (acc + pop) - per_slots) > 8 || (per_slots - 2 * (acc + pop)) > 8) begin
                  m_fail++;
                  $display("FAIL R6: 2*high %0d expected %0d within 8", 2 * (acc + pop), per_slots);
               end
            end
            acc = 0;
         end
      end else acc = 0;
   end

   task automatic load_code(int c, int f);
      @(negedge clk);
      code_valid  = 1'b1;
      code_coarse = 8'(c);
      code_fine   = 3'(f);
      @(negedge clk);
      code_valid  = 1'b0;
   endtask

   // one scenario: load, check lock, measure n-1 runs
   task automatic scenario(int c, int f, int p, int duty, int n, string tag);
      int h;
      h = (p * duty + 50) / 100;
      if (h < 1) h = 1;
      if (h > p - 1) h = p - 1;
      load_code(c, f);
      exp_w = half_of(c, f);
      per_slots = p * 8;
      n_runs = 0;
      for (int k = 0; k < n; k++) begin
         if (k == 1) begin
            chk(locked == 1'b0, "R8 lock low after first edge", int'(locked), 0);
            meas_en = 1;
         end
         if (k == 2) chk(locked == 1'b1, "R8 lock high after second edge", int'(locked), 1);
         clk_in = 1'b1;
         repeat (h) @(negedge clk);
         clk_in = 1'b0;
         repeat (p - h) @(negedge clk);
      end
      meas_en = 0;
      chk(n_runs == n - 1, {"R4 run count ", tag}, n_runs, n - 1);
   endtask

   initial begin
      void'($urandom(32'd20211));
      repeat (3) @(negedge clk);
      chk(out_phases == 8'h00, "R1 out_phases reset", int'(out_phases), 0);
      chk(clk_out == 1'b0, "R1 clk_out reset", int'(clk_out), 0);
      chk(locked == 1'b0, "R1 locked reset", int'(locked), 0);
      rst_n = 1'b1;

      // R2: toggling with no code
      for (int k = 0; k < 4; k++) begin
         clk_in = 1'b1;
         repeat (6) begin @(negedge clk); if (out_phases != 0 || locked) idle_bad++; end
         clk_in = 1'b0;
         repeat (6) begin @(negedge clk); if (out_phases != 0 || locked) idle_bad++; end
      end
      chk(idle_bad == 0, "R2 idle output", idle_bad, 0);

      // R6: same code, three duties
      scenario(20, 0, 20, 50, 6, "R6 d50");
      scenario(20, 0, 20, 30, 6, "R6 d30");
      scenario(20, 0, 20, 70, 6, "R6 d70");
      // R3 carry corner cases
      scenario(25, 5, 25, 50, 5, "R3 odd coarse");
      scenario(24, 7, 24, 40, 5, "R3 even coarse");
      scenario(32, 1, 32, 60, 5, "R5 slot zero");
      scenario(11, 0, 11, 50, 5, "R3 short");

      // R7: set and reset coincide
      load_code(1, 0);
      for (int k = 0; k < 4; k++) begin
         clk_in = 1'b1;
         repeat (5) @(negedge clk);
         clk_in = 1'b0;
         repeat (7) begin @(negedge clk); if (k > 0 && out_phases != 8'hFF) stuck_bad++; end
      end
      chk(stuck_bad == 0, "R7 set wins, output stays high", stuck_bad, 0);
      chk(out_phases == 8'hFF, "R7 final vector", int'(out_phases), 255);

      // R9: recovery with a fresh code
      scenario(16, 3, 16, 50, 5, "R9 recovery");

      // random mix
      for (int r = 0; r < 10; r++) begin
         int p, c, f, d;
         p = 10 + int'($urandom % 40);
         d = 30 + int'($urandom % 41);
         c = p;
         f = int'($urandom % 8);
         scenario(c, f, p, d, 5, "R3 random");
      end

      n_chk += m_chk;
      n_fail += m_fail;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk += m_chk + 1;
         n_fail += m_fail + 1;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule